// File: doc/BRIEF.md
# 16-bit Sliced ALU with Carry Lookahead

This block is a purely combinational 16-bit arithmetic and logic unit. It is built from four identical 4-bit slices. Every slice receives the same 4-bit function code and the same mode bit, and computes its share of the result. Each slice also reports an active-low group-propagate and group-generate pair. A separate lookahead unit turns those pairs and the external carry into the carry inputs of the three upper slices. All three carries are formed at once as two-level sum-of-products terms, so no carry ripples from slice to slice.

The mode bit chooses between sixteen bitwise functions of the two operands and sixteen arithmetic functions. The carry input and the carry output are active low, so an asserted carry is a 0. The lookahead unit also forms block-level propagate and generate outputs. Together with the carry output, these let a wider word be built by placing several blocks side by side.

Top module: `alu_lc16`

## Requirements
- R1: With `mode_logic`=1, `res` is a bitwise function of `op_a` (A) and `op_b` (B) selected by `fsel`: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R2: With `mode_logic`=1, `res` does not depend on `cin_n`.
- R3: With `mode_logic`=0 and `cin_n`=1, `res` is the low 16 bits of T1+T2, where (T1,T2) for each `fsel` value is: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (FFFF,0), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (FFFF,A&~B), 8 (A,A&B), 9 (A,B), 10 (A|~B,A&B), 11 (FFFF,A&B), 12 (A,A), 13 (A|B,A), 14 (A|~B,A), 15 (FFFF,A).
- R4: With `mode_logic`=0 and `cin_n`=0, `res` is the low 16 bits of T1+T2+1.
- R5: In arithmetic mode, `cout_n` is 0 exactly when T1+T2+(1 if `cin_n`=0) is at least 65536.
- R6: `grp_g_n` is 0 exactly when T1+T2 with no carry in is at least 65536.
- R7: At least one of `grp_g_n` and `grp_p_n` is 0 exactly when T1+T2+1 is at least 65536.
- R8: Carries cross every slice boundary in the same evaluation. For example, FFFF plus one gives a result of 0000 and a 0 on `cout_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| fsel | input | 4 | Function code shared by all slices |
| mode_logic | input | 1 | 1 selects bitwise functions, 0 selects arithmetic |
| cin_n | input | 1 | Carry into bit 0, active low |
| res | output | 16 | Result |
| grp_p_n | output | 1 | Block propagate, active low |
| grp_g_n | output | 1 | Block generate, active low |
| cout_n | output | 1 | Carry out of bit 15, active low |

## Verification
The checker's properties assume that every input is at a defined 0 or 1 and that the outputs are sampled only after the combinational network has settled for a given input set. The bench drives only two-valued operands. After each change it waits a fixed settle time and only then samples. It sweeps both modes, all sixteen function codes and both carry values, over boundary operands and random operands.

// File: rtl/alu_lc_pkg.sv
package alu_lc_pkg;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } alu_mode_e;

    // active-low propagate/generate pair of one group
    typedef struct packed {
        logic p_n;
        logic g_n;
    } grp_pg_t;

    // per-bit OR-type term: A, plus B under fsel[0], plus ~B under fsel[1]
    function automatic logic bit_or_term(input logic a, input logic b, input logic [3:0] fs);
        return a | (b & fs[0]) | (~b & fs[1]);
    endfunction

    // per-bit AND-type term: A&~B under fsel[2], A&B under fsel[3]
    function automatic logic bit_and_term(input logic a, input logic b, input logic [3:0] fs);
        return (a & ~b & fs[2]) | (a & b & fs[3]);
    endfunction

endpackage

// File: rtl/alu_lc_cla.sv
module alu_lc_cla #(
    parameter int N = 4
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] gen,
    input  logic         c0,
    output logic [N:0]   carry,
    output logic         blk_p,
    output logic         blk_g
);
    // two-level carry terms for every position at once
    always_comb begin
        carry[0] = c0;
        for (int k = 1; k <= N; k++) begin
            logic acc;
            logic pall;
            pall = 1'b1;
            for (int j = 0; j < k; j++) pall = pall & prop[j];
            acc = pall & c0;
            for (int j = 0; j < k; j++) begin
                logic term;
                term = gen[j];
                for (int m = j + 1; m < k; m++) term = term & prop[m];
                acc = acc | term;
            end
            carry[k] = acc;
        end
    end

    always_comb begin
        blk_p = &prop;
        blk_g = 1'b0;
        for (int j = 0; j < N; j++) begin
            logic term;
            term = gen[j];
            for (int m = j + 1; m < N; m++) term = term & prop[m];
            blk_g = blk_g | term;
        end
    end
endmodule

// File: rtl/alu_lc_slice.sv
module alu_lc_slice
    import alu_lc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fsel,
    input  alu_mode_e    mode,
    input  logic         cin_n,
    output logic [W-1:0] f,
    output grp_pg_t      pg
);
    logic [W-1:0] xo;
    logic [W-1:0] ya;
    logic [W:0]   c;
    logic         sp;
    logic         sg;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign xo[i] = bit_or_term(a[i], b[i], fsel);
            assign ya[i] = bit_and_term(a[i], b[i], fsel);
        end
    endgenerate

    // in-slice lookahead; ya implies xo, so ya is generate and xo propagate
    alu_lc_cla #(.N(W)) u_cla (
        .prop  (xo),
        .gen   (ya),
        .c0    (~cin_n),
        .carry (c),
        .blk_p (sp),
        .blk_g (sg)
    );

    always_comb begin
        if (mode == MODE_LOGIC) f = ~(xo ^ ya);
        else                    f = xo ^ ya ^ c[W-1:0];
    end

    assign pg.p_n = ~sp;
    assign pg.g_n = ~sg;
endmodule

// File: rtl/alu_lc16.sv
module alu_lc16
    import alu_lc_pkg::*;
#(
    parameter int SLICE_W  = 4,
    parameter int N_SLICES = 4,
    localparam int DW      = SLICE_W * N_SLICES
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    fsel,
    input  logic          mode_logic,
    input  logic          cin_n,
    output logic [DW-1:0] res,
    output logic          grp_p_n,
    output logic          grp_g_n,
    output logic          cout_n
);
    alu_mode_e               mode;
    grp_pg_t [N_SLICES-1:0]  spg;
    logic    [N_SLICES-1:0]  sp;
    logic    [N_SLICES-1:0]  sg;
    logic    [N_SLICES:0]    la_c;
    logic    [N_SLICES-1:0]  slice_cin_n;
    logic                    bp;
    logic                    bg;

    assign mode = alu_mode_e'(mode_logic);

    generate
        for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
            if (s == 0) begin : g_first
                assign slice_cin_n[s] = cin_n;
            end else begin : g_upper
                assign slice_cin_n[s] = ~la_c[s];
            end
            assign sp[s] = ~spg[s].p_n;
            assign sg[s] = ~spg[s].g_n;
            alu_lc_slice #(.W(SLICE_W)) u_slice (
                .a     (op_a[s*SLICE_W +: SLICE_W]),
                .b     (op_b[s*SLICE_W +: SLICE_W]),
                .fsel  (fsel),
                .mode  (mode),
                .cin_n (slice_cin_n[s]),
                .f     (res[s*SLICE_W +: SLICE_W]),
                .pg    (spg[s])
            );
        end
    endgenerate

    alu_lc_cla #(.N(N_SLICES)) u_la (
        .prop  (sp),
        .gen   (sg),
        .c0    (~cin_n),
        .carry (la_c),
        .blk_p (bp),
        .blk_g (bg)
    );

    assign grp_p_n = ~bp;
    assign grp_g_n = ~bg;
    assign cout_n  = ~la_c[N_SLICES];
endmodule

// File: rtl/alu_lc16_chk.sv
module alu_lc16_chk #(
    parameter int DW = 16
) (
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [3:0]    fsel,
    input logic          mode_logic,
    input logic          cin_n,
    input logic [DW-1:0] res,
    input logic          grp_p_n,
    input logic          grp_g_n,
    input logic          cout_n
);
    logic [DW:0] add_ab;
    logic [DW:0] add_anb;
    assign add_ab  = {1'b0, op_a} + {1'b0, op_b} + {{DW{1'b0}}, ~cin_n};
    assign add_anb = {1'b0, op_a} + {1'b0, ~op_b} + {{DW{1'b0}}, ~cin_n};

    always_comb begin
        if (mode_logic && fsel == 4'd6)
            AST_LOGIC_XOR: assert (res == (op_a ^ op_b));                     // R1
        if (mode_logic && fsel == 4'd11)
            AST_LOGIC_AND: assert (res == (op_a & op_b));                     // R1
        if (!mode_logic && fsel == 4'd9)
            AST_ARITH_ADD: assert ({~cout_n, res} == add_ab);                 // R4
        if (!mode_logic && fsel == 4'd6)
            AST_ARITH_SUB: assert ({~cout_n, res} == add_anb);                // R3
        if (!grp_g_n)
            AST_GEN_FORCES_CARRY: assert (!cout_n);                           // R6
        if (grp_g_n && !grp_p_n)
            AST_PROP_PASSES_CARRY: assert (cout_n == cin_n);                  // R7
    end
endmodule

bind alu_lc16 alu_lc16_chk #(.DW(DW)) u_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .fsel       (fsel),
    .mode_logic (mode_logic),
    .cin_n      (cin_n),
    .res        (res),
    .grp_p_n    (grp_p_n),
    .grp_g_n    (grp_g_n),
    .cout_n     (cout_n)
);

// File: tb/alu_lc16_tb.sv
`timescale 1ns/1ps
module alu_lc16_tb;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [3:0]  fsel = '0;
    logic        mode_logic = 1'b0;
    logic        cin_n = 1'b1;
    logic [15:0] res;
    logic        grp_p_n, grp_g_n, cout_n;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    alu_lc16 u_dut (
        .op_a(op_a), .op_b(op_b), .fsel(fsel), .mode_logic(mode_logic),
        .cin_n(cin_n), .res(res), .grp_p_n(grp_p_n), .grp_g_n(grp_g_n),
        .cout_n(cout_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] ref_logic(input logic [3:0] s, input logic [15:0] a, input logic [15:0] b);
        case (s)
            4'd0:  return ~a;
            4'd1:  return ~(a | b);
            4'd2:  return ~a & b;
            4'd3:  return 16'h0000;
            4'd4:  return ~(a & b);
            4'd5:  return ~b;
            4'd6:  return a ^ b;
            4'd7:  return a & ~b;
            4'd8:  return ~a | b;
            4'd9:  return ~(a ^ b);
            4'd10: return b;
            4'd11: return a & b;
            4'd12: return 16'hFFFF;
            4'd13: return a | ~b;
            4'd14: return a | b;
            default: return a;
        endcase
    endfunction

    function automatic logic [31:0] ref_terms(input logic [3:0] s, input logic [15:0] a, input logic [15:0] b);
        case (s)
            4'd0:  return {a, 16'h0};
            4'd1:  return {a | b, 16'h0};
            4'd2:  return {a | ~b, 16'h0};
            4'd3:  return {16'hFFFF, 16'h0};
            4'd4:  return {a, a & ~b};
            4'd5:  return {a | b, a & ~b};
            4'd6:  return {a, ~b};
            4'd7:  return {16'hFFFF, a & ~b};
            4'd8:  return {a, a & b};
            4'd9:  return {a, b};
            4'd10: return {a | ~b, a & b};
            4'd11: return {16'hFFFF, a & b};
            4'd12: return {a, a};
            4'd13: return {a | b, a};
            4'd14: return {a | ~b, a};
            default: return {16'hFFFF, a};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: mode=%0d fsel=%0d a=%h b=%h cin_n=%0d actual=%h expected=%h",
                     tag, mode_logic, fsel, op_a, op_b, cin_n, act, exp);
        end
    endtask

    task automatic run_vec(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] t;
        logic [16:0] s0, s1;
        logic [15:0] f_hi;
        op_a = a;
        op_b = b;
        t  = ref_terms(fsel, a, b);
        s0 = {1'b0, t[31:16]} + {1'b0, t[15:0]};
        s1 = s0 + 17'd1;
        cin_n = 1'b1;
        #4;
        f_hi = res;
        if (mode_logic) begin
            chk("R1", {1'b0, res}, {1'b0, ref_logic(fsel, a, b)});
        end else begin
            chk("R3", {1'b0, res}, {1'b0, s0[15:0]});
            chk("R5", {16'h0, ~cout_n}, {16'h0, s0[16]});
        end
        chk("R6", {16'h0, ~grp_g_n}, {16'h0, s0[16]});
        chk("R7", {16'h0, ~(grp_g_n & grp_p_n)}, {16'h0, s1[16]});
        cin_n = 1'b0;
        #4;
        if (mode_logic) begin
            chk("R2", {1'b0, res}, {1'b0, f_hi});
        end else begin
            chk("R4", {1'b0, res}, {1'b0, s1[15:0]});
            chk("R5", {16'h0, ~cout_n}, {16'h0, s1[16]});
        end
        #2;
    endtask

    localparam logic [15:0] CORNER [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
                                           16'h5555, 16'hAAAA, 16'h0FFF, 16'h0001};

    initial begin
        // idle state: all-zero inputs, arithmetic code 0, no carry -> result 0
        #4;
        chk("R3", {cout_n, res}, {1'b1, 16'h0000});
        // R8: carry through all slice boundaries
        mode_logic = 1'b0; fsel = 4'd9; op_a = 16'hFFFF; op_b = 16'h0000; cin_n = 1'b0;
        #4;
        chk("R8", {cout_n, res}, {1'b0, 16'h0000});
        op_a = 16'h0FFF; op_b = 16'h0001; cin_n = 1'b1;
        #4;
        chk("R8", {cout_n, res}, {1'b1, 16'h1000});
        op_a = 16'h00FF; op_b = 16'hFF00; cin_n = 1'b0;
        #4;
        chk("R8", {cout_n, res}, {1'b0, 16'h0000});
        for (int m = 0; m < 2; m++) begin
            mode_logic = m[0];
            for (int s = 0; s < 16; s++) begin
                fsel = s[3:0];
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_vec(CORNER[i], CORNER[j]);
                for (int n = 0; n < 120; n++)
                    run_vec(16'($urandom), 16'($urandom));
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule